// File: doc/BRIEF.md
# Enable-Gated Watchdog Supervisor

This block watches a processor's service signal. The processor proves that it is alive by producing falling edges on a kick input. If no such edge arrives within the selected timeout, the block drives an active-low fault output low for a fixed reset-delay period. It then releases the output and starts a new timeout period. All timing is counted in ticks of an internal prescaler, and each period starts from a fresh prescaler phase. A period of N ticks therefore always spans exactly N × `TICK_DIV` clock cycles.

The watchdog can be stopped in two ways. Dropping `en` stops it and also lowers the enable-status output `enout`, which falls `EN_DLY_CYC` cycles later. When `en` returns, the block first runs a reset-delay period with both outputs low. Lowering `set1` parks the watchdog and leaves `enout` as it is. When `set1` rises again, a short setup window runs before timing resumes. A power-good flag `pgood` holds both outputs low while it is low. When it rises, a startup delay runs first.

A two-bit mode code selects the timeout: a long preset, a short preset, or a value derived from a capacitance given in tenths of a nanofarad.

States: `ST_PWROFF` (power not good), `ST_STARTUP` (startup delay), `ST_OFF` (disabled by `en`), `ST_ENDLY` (reset delay after enable), `ST_PARKED` (disabled by `set1`), `ST_SETUP` (re-enable dead time), `ST_WATCH` (counting the timeout), `ST_FAULT` (fault pulse).

Transitions:
- Any state goes to PWROFF when `pgood` is low.
- PWROFF goes to STARTUP.
- STARTUP goes to ENDLY or OFF when the delay ends, depending on `en`.
- OFF goes to ENDLY when `en` rises.
- ENDLY goes to WATCH or PARKED when the delay ends, depending on `set1`.
- PARKED goes to SETUP when `set1` rises.
- SETUP goes to WATCH when the window ends.
- WATCH goes to FAULT on expiry. A kick keeps it in WATCH and restarts the count.
- FAULT goes to WATCH when the pulse ends.
- ENDLY, PARKED, SETUP, WATCH and FAULT go to OFF when `en` is low.
- SETUP, WATCH and FAULT go to PARKED when `set1` is low. When `en` is also low, OFF takes priority.

Top module: `wdog_supervisor`

## Requirements
- R1: While reset is asserted, and in the cycle after `pgood` is sampled low, `wdo_n` is 0 and `enout` is 0.
- R2: When `pgood` rises, the block stays in the startup delay for `STARTUP_TICKS` ticks. During this delay `wdo_n` is 0, `enout` is 0 and kicks are ignored. At the end, it enters the reset delay if `en` is 1 and the disabled state if `en` is 0. In the disabled state `wdo_n` is 1 and `enout` is 0.
- R3: After `en` rises, or after the startup delay with `en` high, `wdo_n` and `enout` stay 0 for 200 ms of ticks. Both go to 1 together at the end of that period. Kicks during the period do not shorten or restart it, and timing starts at its end.
- R4: In the watching state, a 1-to-0 transition of `kick` restarts the timeout, with the restart taking effect three clock edges after the transition. A 0-to-1 transition does not restart it.
- R5: When a full timeout passes without a kick, `wdo_n` goes to 0 for 200 ms of ticks while `enout` stays 1. `wdo_n` then returns to 1 and a new timeout period begins.
- R6: A falling kick edge during the fault pulse neither shortens nor extends the pulse.
- R7: With `pgood` high, a low `en` releases `wdo_n` to 1 at the next edge and clears all timing. `enout` falls exactly `EN_DLY_CYC` edges after `en` is first sampled low.
- R8: A low `set1` parks the watchdog. `wdo_n` stays 1, no timeout occurs and kicks are ignored, while `enout` keeps its value.
- R9: After `set1` rises, kicks are ignored for `SETUP_TICKS` ticks, and the timeout period starts when that window ends.
- R10: The mode code sets the timeout. Code 00 gives 1600 ms. Code 01 gives 200 ms. Codes 10 and 11 give floor(7.74 × `cap_tenths`) + 55 ms, where `cap_tenths` is the capacitance in units of 0.1 nF. One millisecond is `TICKS_PER_MS` ticks.
- R11: When `en` drops during a fault pulse, `wdo_n` is released to 1 at the next edge.
- R12: When `pgood` falls in any state, including during a fault, the block returns to the power-off condition of R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pgood | input | 1 | Supply good flag, synchronous to clk |
| en | input | 1 | Enable; low disables the watchdog and lowers enout |
| set1 | input | 1 | Watchdog run select; low parks the watchdog |
| kick | input | 1 | Service input, asynchronous; falling edges count |
| mode | input | 2 | Timeout select: 00 long, 01 short, 1x capacitance-derived |
| cap_tenths | input | CAP_W | Capacitance in units of 0.1 nF for the capacitance-derived modes |
| wdo_n | output | 1 | Active-low watchdog fault |
| enout | output | 1 | Active-high enable status |

## Verification
The assertions assume that `en`, `set1` and `pgood` are already synchronous to `clk`; only `kick` goes through the internal synchroniser. They also assume that `mode` and `cap_tenths` stay steady within a timed period, because a change in mid-period moves the expiry point. The stimulus changes every input on the falling clock edge. It changes the mode code only just after a new watching period or fault pulse has begun, and it keeps `cap_tenths` constant for the whole run.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [2:0] {
        ST_PWROFF,
        ST_STARTUP,
        ST_OFF,
        ST_ENDLY,
        ST_PARKED,
        ST_SETUP,
        ST_WATCH,
        ST_FAULT
    } wd_state_e;

    typedef enum logic [1:0] {
        MD_LONG    = 2'b00,
        MD_SHORT   = 2'b01,
        MD_CAP     = 2'b10,
        MD_CAP_ALT = 2'b11
    } wd_mode_e;

    // nominal periods in milliseconds
    localparam int LONG_MS     = 1600;
    localparam int SHORT_MS    = 200;
    localparam int RST_MS      = 200;
    // capacitance-derived timeout: hundredths of a ms per 0.1 nF, plus a base
    localparam int CAP_SLOPE_CENT = 774;
    localparam int CAP_BASE_MS    = 55;

endpackage

// File: rtl/wdog_kick_sync.sv
module wdog_kick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick_in,
    output logic fall
);

    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // stage 0 samples the asynchronous pin, later stages settle it
    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[0] <= 1'b1;
                    else        sync_q[0] <= kick_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[gi] <= 1'b1;
                    else        sync_q[gi] <= sync_q[gi-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b1;
        else        last_q <= sync_q[STAGES-1];
    end

    assign fall = last_q & ~sync_q[STAGES-1];

endmodule

// File: rtl/wdog_interval.sv
module wdog_interval #(
    parameter int TICK_DIV = 100,
    parameter int CNT_W    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic             done,
    output logic [CNT_W-1:0] count
);

    localparam int             PRE_W    = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

    logic [PRE_W-1:0] pre;
    logic             tick;

    assign tick = (pre == PRE_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre   <= '0;
            count <= '0;
        end else if (restart) begin
            pre   <= '0;
            count <= '0;
        end else if (tick) begin
            pre   <= '0;
            count <= count + CNT_W'(1);
        end else begin
            pre   <= pre + PRE_W'(1);
        end
    end

    // expiry on the tick that completes the limit-th whole tick
    assign done = tick && (count >= limit - CNT_W'(1));

endmodule

// File: rtl/wdog_limit.sv
module wdog_limit
    import wdog_pkg::*;
#(
    parameter int TICKS_PER_MS  = 1000,
    parameter int STARTUP_TICKS = 300,
    parameter int SETUP_TICKS   = 150,
    parameter int CAP_W         = 14,
    parameter int CNT_W         = 32
) (
    input  wd_state_e        state,
    input  logic [1:0]       mode,
    input  logic [CAP_W-1:0] cap_tenths,
    output logic [CNT_W-1:0] limit
);

    localparam logic [CNT_W-1:0] TPM_L     = CNT_W'(TICKS_PER_MS);
    localparam logic [CNT_W-1:0] START_L   = CNT_W'(STARTUP_TICKS);
    localparam logic [CNT_W-1:0] SETUP_L   = CNT_W'(SETUP_TICKS);
    localparam logic [CNT_W-1:0] RST_L     = CNT_W'(RST_MS * TICKS_PER_MS);
    localparam logic [CNT_W-1:0] LONG_L    = CNT_W'(LONG_MS);
    localparam logic [CNT_W-1:0] SHORT_L   = CNT_W'(SHORT_MS);
    localparam logic [CNT_W-1:0] SLOPE_L   = CNT_W'(CAP_SLOPE_CENT);
    localparam logic [CNT_W-1:0] BASE_L    = CNT_W'(CAP_BASE_MS);
    localparam logic [CNT_W-1:0] HUNDRED_L = CNT_W'(100);

    logic [CNT_W-1:0] watch_ms;

    always_comb begin
        case (wd_mode_e'(mode))
            MD_LONG:  watch_ms = LONG_L;
            MD_SHORT: watch_ms = SHORT_L;
            default:  watch_ms = (CNT_W'(cap_tenths) * SLOPE_L) / HUNDRED_L + BASE_L;
        endcase
    end

    always_comb begin
        case (state)
            ST_STARTUP:        limit = START_L;
            ST_SETUP:          limit = SETUP_L;
            ST_ENDLY, ST_FAULT: limit = RST_L;
            ST_WATCH:          limit = watch_ms * TPM_L;
            default:           limit = '1;
        endcase
    end

endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor
    import wdog_pkg::*;
#(
    parameter int TICK_DIV      = 100,
    parameter int TICKS_PER_MS  = 1000,
    parameter int STARTUP_TICKS = 300,
    parameter int SETUP_TICKS   = 150,
    parameter int EN_DLY_CYC    = 20,
    parameter int SYNC_STAGES   = 2,
    parameter int CAP_W         = 14,
    parameter int CNT_W         = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pgood,
    input  logic             en,
    input  logic             set1,
    input  logic             kick,
    input  logic [1:0]       mode,
    input  logic [CAP_W-1:0] cap_tenths,
    output logic             wdo_n,
    output logic             enout
);

    wd_state_e        state;
    wd_state_e        st_nx;
    logic [CNT_W-1:0] tmr;
    logic [CNT_W-1:0] limit;
    logic             done;
    logic             restart;
    logic             timed;
    logic             kick_fall;
    logic             kick_act;
    logic             up_q;
    logic             en_late;

    // ---------------------------------------------------------------
    // kick synchroniser and falling-edge detector
    // ---------------------------------------------------------------
    wdog_kick_sync #(
        .STAGES (SYNC_STAGES)
    ) u_kick (
        .clk     (clk),
        .rst_n   (rst_n),
        .kick_in (kick),
        .fall    (kick_fall)
    );

    // ---------------------------------------------------------------
    // per-state period length and shared interval counter
    // ---------------------------------------------------------------
    wdog_limit #(
        .TICKS_PER_MS  (TICKS_PER_MS),
        .STARTUP_TICKS (STARTUP_TICKS),
        .SETUP_TICKS   (SETUP_TICKS),
        .CAP_W         (CAP_W),
        .CNT_W         (CNT_W)
    ) u_limit (
        .state      (state),
        .mode       (mode),
        .cap_tenths (cap_tenths),
        .limit      (limit)
    );

    wdog_interval #(
        .TICK_DIV (TICK_DIV),
        .CNT_W    (CNT_W)
    ) u_ival (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .limit   (limit),
        .done    (done),
        .count   (tmr)
    );

    // ---------------------------------------------------------------
    // enable-status fall delay line
    // ---------------------------------------------------------------
    generate
        if (EN_DLY_CYC <= 1) begin : g_dly_one
            logic q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= 1'b0;
                else        q <= en;
            end
            assign en_late = q;
        end else begin : g_dly_many
            logic [EN_DLY_CYC-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= '0;
                else        q <= {q[EN_DLY_CYC-2:0], en};
            end
            assign en_late = q[EN_DLY_CYC-1];
        end
    endgenerate

    // ---------------------------------------------------------------
    // next-state logic
    // ---------------------------------------------------------------
    assign kick_act = (state == ST_WATCH) && kick_fall && pgood && en && set1;

    always_comb begin
        st_nx = state;
        if (!pgood) begin
            st_nx = ST_PWROFF;
        end else begin
            unique case (state)
                ST_PWROFF: begin
                    st_nx = ST_STARTUP;
                end
                ST_STARTUP: begin
                    if (done) st_nx = en ? ST_ENDLY : ST_OFF;
                end
                ST_OFF: begin
                    if (en) st_nx = ST_ENDLY;
                end
                ST_ENDLY: begin
                    if (!en)       st_nx = ST_OFF;
                    else if (done) st_nx = set1 ? ST_WATCH : ST_PARKED;
                end
                ST_PARKED: begin
                    if (!en)       st_nx = ST_OFF;
                    else if (set1) st_nx = ST_SETUP;
                end
                ST_SETUP: begin
                    if (!en)        st_nx = ST_OFF;
                    else if (!set1) st_nx = ST_PARKED;
                    else if (done)  st_nx = ST_WATCH;
                end
                ST_WATCH: begin
                    if (!en)           st_nx = ST_OFF;
                    else if (!set1)    st_nx = ST_PARKED;
                    else if (kick_act) st_nx = ST_WATCH;
                    else if (done)     st_nx = ST_FAULT;
                end
                ST_FAULT: begin
                    if (!en)        st_nx = ST_OFF;
                    else if (!set1) st_nx = ST_PARKED;
                    else if (done)  st_nx = ST_WATCH;
                end
            endcase
        end
    end

    assign timed   = state inside {ST_STARTUP, ST_ENDLY, ST_SETUP, ST_WATCH, ST_FAULT};
    assign restart = (st_nx != state) || kick_act || !timed;

    // ---------------------------------------------------------------
    // state register
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_PWROFF;
        else        state <= st_nx;
    end

    // enable-status qualifier: set once the reset delay completes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            up_q <= 1'b0;
        end else if (st_nx inside {ST_PWROFF, ST_STARTUP, ST_ENDLY}) begin
            up_q <= 1'b0;
        end else if (st_nx inside {ST_PARKED, ST_SETUP, ST_WATCH, ST_FAULT}) begin
            up_q <= 1'b1;
        end
    end

    // ---------------------------------------------------------------
    // outputs
    // ---------------------------------------------------------------
    always_comb begin
        unique case (state)
            ST_PWROFF, ST_STARTUP, ST_ENDLY, ST_FAULT: wdo_n = 1'b0;
            ST_OFF, ST_PARKED, ST_SETUP, ST_WATCH:     wdo_n = 1'b1;
        endcase
        enout = up_q & en_late;
    end

endmodule

// File: rtl/wdog_supervisor_chk.sv
module wdog_supervisor_chk
    import wdog_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pgood,
    input logic             en,
    input logic             set1,
    input logic             wdo_n,
    input logic             enout,
    input wd_state_e        state,
    input logic [CNT_W-1:0] tmr
);

    // R1 and R12: power not good forces both outputs low
    p_pwr_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pgood) |-> (!wdo_n && !enout));

    // R7: a low enable releases the fault output at the next edge
    p_en_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!en && pgood && state != ST_STARTUP && state != ST_PWROFF) |-> wdo_n);

    // R8: a low run select parks the watchdog with the fault output released
    p_set1_park_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en && pgood && !set1 &&
              (state inside {ST_WATCH, ST_FAULT, ST_SETUP, ST_PARKED}))
        |-> (wdo_n && state == ST_PARKED));

    // R5: a fault pulse can only begin from the watching state
    p_fault_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FAULT && $past(state) != ST_FAULT) |-> $past(state) == ST_WATCH);

    // R9: leaving the parked state always passes through the setup window
    p_setup_path_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(state == ST_PARKED && pgood && en) |-> (state == ST_PARKED || state == ST_SETUP));

    // R3: enable status only rises while enable and power are good
    p_enout_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enout) |-> ($past(en) && $past(pgood)));

    // R6: nothing restarts the count inside a fault pulse
    p_fault_kick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_FAULT && state == ST_FAULT) |-> tmr >= $past(tmr));

endmodule

bind wdog_supervisor wdog_supervisor_chk #(
    .CNT_W (CNT_W)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .pgood (pgood),
    .en    (en),
    .set1  (set1),
    .wdo_n (wdo_n),
    .enout (enout),
    .state (state),
    .tmr   (tmr)
);

// File: tb/wdog_supervisor_tb.sv
module wdog_supervisor_tb;

    localparam int CLK_PERIOD    = 10;
    localparam int TICK_DIV      = 2;
    localparam int TICKS_PER_MS  = 1;
    localparam int STARTUP_TICKS = 10;
    localparam int SETUP_TICKS   = 6;
    localparam int EN_DLY_CYC    = 4;
    localparam int CAP_W         = 14;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             pgood;
    logic             en;
    logic             set1;
    logic             kick;
    logic [1:0]       mode;
    logic [CAP_W-1:0] cap_tenths;
    logic             wdo_n;
    logic             enout;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_supervisor #(
        .TICK_DIV      (TICK_DIV),
        .TICKS_PER_MS  (TICKS_PER_MS),
        .STARTUP_TICKS (STARTUP_TICKS),
        .SETUP_TICKS   (SETUP_TICKS),
        .EN_DLY_CYC    (EN_DLY_CYC),
        .CAP_W         (CAP_W)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pgood      (pgood),
        .en         (en),
        .set1       (set1),
        .kick       (kick),
        .mode       (mode),
        .cap_tenths (cap_tenths),
        .wdo_n      (wdo_n),
        .enout      (enout)
    );

    // one period of N ticks = 2N cycles; 200 ms = 400 cycles,
    // 1600 ms = 3200 cycles, cap 1.0 nF -> 132 ms = 264 cycles
    typedef struct packed {
        logic        pg;
        logic        en;
        logic        s1;
        logic        kick;
        logic [1:0]  mode;
        logic [15:0] cyc;
        logic        wdo;
        logic        eno;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 43;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b1,1'b1,1'b1,2'b01,16'd5,   1'b0,1'b0,8'd1 },  // R1 power low
        '{1'b1,1'b1,1'b1,1'b1,2'b01,16'd19,  1'b0,1'b0,8'd2 },  // R2 inside startup
        '{1'b1,1'b1,1'b1,1'b1,2'b01,16'd2,   1'b0,1'b0,8'd3 },  // R3 delay begins
        '{1'b1,1'b1,1'b1,1'b1,2'b01,16'd398, 1'b0,1'b0,8'd3 },  // R3 last cycle of delay
        '{1'b1,1'b1,1'b1,1'b1,2'b01,16'd2,   1'b1,1'b1,8'd3 },  // R3 both outputs up
        '{1'b1,1'b1,1'b1,1'b1,2'b01,16'd395, 1'b1,1'b1,8'd5 },  // R5 before expiry
        '{1'b1,1'b1,1'b1,1'b1,2'b01,16'd5,   1'b0,1'b1,8'd5 },  // R5 fault pulse
        '{1'b1,1'b1,1'b1,1'b1,2'b01,16'd399, 1'b0,1'b1,8'd5 },  // R5 pulse still low
        '{1'b1,1'b1,1'b1,1'b1,2'b01,16'd1,   1'b1,1'b1,8'd5 },  // R5 released
        '{1'b1,1'b1,1'b1,1'b1,2'b01,16'd300, 1'b1,1'b1,8'd4 },  // R4 idle high
        '{1'b1,1'b1,1'b1,1'b0,2'b01,16'd200, 1'b1,1'b1,8'd4 },  // R4 falling kick saves
        '{1'b1,1'b1,1'b1,1'b1,2'b01,16'd200, 1'b1,1'b1,8'd4 },  // R4 rising kick
        '{1'b1,1'b1,1'b1,1'b1,2'b01,16'd5,   1'b0,1'b1,8'd4 },  // R4 rising did not restart
        '{1'b1,1'b1,1'b1,1'b0,2'b01,16'd100, 1'b0,1'b1,8'd6 },  // R6 kick inside pulse
        '{1'b1,1'b1,1'b1,1'b1,2'b01,16'd297, 1'b0,1'b1,8'd6 },  // R6 pulse not shortened
        '{1'b1,1'b1,1'b1,1'b1,2'b01,16'd1,   1'b1,1'b1,8'd6 },  // R6 pulse not extended
        '{1'b1,1'b0,1'b1,1'b1,2'b01,16'd3,   1'b1,1'b1,8'd7 },  // R7 enout not yet low
        '{1'b1,1'b0,1'b1,1'b1,2'b01,16'd1,   1'b1,1'b0,8'd7 },  // R7 enout low on time
        '{1'b1,1'b0,1'b1,1'b1,2'b01,16'd1000,1'b1,1'b0,8'd7 },  // R7 no timeout while off
        '{1'b1,1'b1,1'b1,1'b1,2'b01,16'd399, 1'b0,1'b0,8'd3 },  // R3 delay after enable
        '{1'b1,1'b1,1'b1,1'b1,2'b01,16'd2,   1'b1,1'b1,8'd3 },  // R3 delay complete
        '{1'b1,1'b1,1'b0,1'b1,2'b01,16'd2000,1'b1,1'b1,8'd8 },  // R8 parked, enout kept
        '{1'b1,1'b1,1'b1,1'b0,2'b01,16'd8,   1'b1,1'b1,8'd9 },  // R9 kick in setup window
        '{1'b1,1'b1,1'b1,1'b1,2'b01,16'd404, 1'b1,1'b1,8'd9 },  // R9 timing from window end
        '{1'b1,1'b1,1'b1,1'b1,2'b01,16'd2,   1'b0,1'b1,8'd9 },  // R9 expiry after window
        '{1'b1,1'b0,1'b1,1'b1,2'b01,16'd2,   1'b1,1'b1,8'd11},  // R11 en low in pulse
        '{1'b1,1'b1,1'b1,1'b1,2'b01,16'd400, 1'b0,1'b0,8'd11},  // R11 re-enable delay
        '{1'b1,1'b1,1'b1,1'b1,2'b01,16'd1,   1'b1,1'b1,8'd3 },  // R3 up again
        '{1'b1,1'b1,1'b1,1'b1,2'b00,16'd1000,1'b1,1'b1,8'd10},  // R10 long mode survives
        '{1'b1,1'b1,1'b1,1'b1,2'b00,16'd2199,1'b1,1'b1,8'd10},  // R10 just before 1600 ms
        '{1'b1,1'b1,1'b1,1'b1,2'b00,16'd2,   1'b0,1'b1,8'd10},  // R10 long expiry
        '{1'b1,1'b1,1'b1,1'b1,2'b00,16'd399, 1'b1,1'b1,8'd10},  // R10 pulse over
        '{1'b1,1'b1,1'b1,1'b1,2'b10,16'd262, 1'b1,1'b1,8'd10},  // R10 cap mode before 132 ms
        '{1'b1,1'b1,1'b1,1'b1,2'b10,16'd3,   1'b0,1'b1,8'd10},  // R10 cap mode expiry
        '{1'b1,1'b1,1'b1,1'b1,2'b11,16'd399, 1'b1,1'b1,8'd10},  // R10 pulse over
        '{1'b1,1'b1,1'b1,1'b1,2'b11,16'd263, 1'b1,1'b1,8'd10},  // R10 code 11 before expiry
        '{1'b1,1'b1,1'b1,1'b1,2'b11,16'd2,   1'b0,1'b1,8'd10},  // R10 code 11 expiry
        '{1'b0,1'b1,1'b1,1'b1,2'b11,16'd1,   1'b0,1'b0,8'd12},  // R12 power drop in pulse
        '{1'b1,1'b0,1'b1,1'b1,2'b01,16'd25,  1'b1,1'b0,8'd2 },  // R2 startup into disabled
        '{1'b1,1'b1,1'b1,1'b1,2'b01,16'd100, 1'b0,1'b0,8'd3 },  // R3 inside delay
        '{1'b1,1'b1,1'b1,1'b0,2'b01,16'd301, 1'b1,1'b1,8'd3 },  // R3 kick in delay ignored
        '{1'b1,1'b1,1'b1,1'b1,2'b01,16'd399, 1'b1,1'b1,8'd3 },  // R3 timing from delay end
        '{1'b1,1'b1,1'b1,1'b1,2'b01,16'd2,   1'b0,1'b1,8'd3 }   // R3 expiry placed correctly
    };

    task automatic check(input int req, input logic exp_wdo, input logic exp_eno,
                         input string what);
        total++;
        if (wdo_n !== exp_wdo || enout !== exp_eno) begin
            bad++;
            $display("FAIL R%0d %s: wdo_n=%b enout=%b expected wdo_n=%b enout=%b",
                     req, what, wdo_n, enout, exp_wdo, exp_eno);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        rst_n      = 1'b0;
        pgood      = 1'b0;
        en         = 1'b1;
        set1       = 1'b1;
        kick       = 1'b1;
        mode       = 2'b01;
        cap_tenths = CAP_W'(10);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(1, 1'b0, 1'b0, "reset state (R1)");
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            pgood = VECS[i].pg;
            en    = VECS[i].en;
            set1  = VECS[i].s1;
            kick  = VECS[i].kick;
            mode  = VECS[i].mode;
            repeat (int'(VECS[i].cyc)) @(posedge clk);
            @(negedge clk);
            check(int'(VECS[i].req), VECS[i].wdo, VECS[i].eno, $sformatf("row %0d", i));
        end

        // R1: asynchronous reset in the middle of a fault pulse
        rst_n = 1'b0;
        #1;
        check(1, 1'b0, 1'b0, "reset asserted during fault (R1)");
        @(negedge clk);
        check(1, 1'b0, 1'b0, "reset held (R1)");

        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: run still going, expected completion");
            summary();
            $finish;
        end
    end

endmodule